// File: doc/BRIEF.md
# Three-Level Programming Pulse Qualifier

This block sits behind two analog comparators that watch a single multiplexed sensor pin. One comparator reports that the pin is above the middle programming level, the other that it is above the highest level. The pin idles at the low level, roughly the normal supply of 4.5 to 5.5 V. Programming pulses rise to a middle level of about 12.5 to 13.5 V, or to a high level of about 18 to 19 V. The block synchronizes and deglitches both comparator flags, then times each excursion above the low level with the system clock. It turns every valid excursion into exactly one clean event for a downstream programming state machine.

A pulse counts only when two timing rules hold. It must stay active for at least 20 µs, and it must follow a low gap of at least 20 µs. The level edges themselves may take up to 100 µs, so the class of a pulse comes from its settled width, never from a single sample. Events fire on the falling edge of the pulse, after the whole excursion has been seen.

A valid pulse is reported as a mid event or as a high event. If its high-level portion lasted at least 90 µs, a blow event is raised together with the high event, marking a pulse that is long enough to set a fuse. All limits are given in microseconds and turned into cycle counts from the clock-frequency parameter.

Top module: `prog_pulse_qualifier`

States of the controller:
- ARM: times the low gap. A rise before the gap is complete goes to REJECT. A complete gap goes to IDLE.
- IDLE: armed. A rise starts the pulse timers and goes to PULSE.
- PULSE: counts active cycles and the current high-level run. A fall emits the event, if the pulse was valid, and returns to ARM.
- REJECT: waits for the discarded pulse to fall, then returns to ARM.

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all three event outputs are low. After reset, a pulse counts only once the pin has been low for the full minimum gap.
- R2: Each comparator flag passes through a two-flop synchronizer. A flag change is honoured only after FILT_LEN consecutive synchronized samples agree, so an excursion or dip lasting fewer than FILT_LEN cycles has no effect on any event.
- R3: The event strobe appears in the cycle after the (FILT_LEN+4)-th rising clock edge, counting the edge that first samples the pin low after a pulse as the first.
- R4: A pulse whose active width (mid or high flag set) is below MIN_ACTIVE_US × CLK_HZ/10^6 cycles emits no event. A pulse of at least that width emits exactly one event.
- R5: A pulse that starts after fewer than MIN_GAP_US × CLK_HZ/10^6 low cycles emits no event. The gap is counted from reset or from the fall of the previous pulse, whether that pulse was accepted or rejected. A gap of exactly the minimum is enough.
- R6: A valid pulse raises evt_high_o if the high flag stayed set for at least the minimum active width in one unbroken run. Otherwise it raises evt_mid_o. Two shorter high runs do not add up.
- R7: evt_blow_o is raised together with evt_high_o when that unbroken high run lasted at least BLOW_MIN_US × CLK_HZ/10^6 cycles. It is never raised alone.
- R8: Every event is a single-cycle strobe, raised only after the pulse has fallen. evt_mid_o and evt_high_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| mid_cmp_i | input | 1 | Asynchronous flag: pin above the middle threshold |
| high_cmp_i | input | 1 | Asynchronous flag: pin above the high threshold |
| evt_mid_o | output | 1 | One-cycle strobe: valid mid-level pulse ended |
| evt_high_o | output | 1 | One-cycle strobe: valid high-level pulse ended |
| evt_blow_o | output | 1 | One-cycle strobe with evt_high_o: high run was long enough to blow a fuse |

## Verification
Every event is due exactly FILT_LEN+4 rising edges after the pin is first sampled low: two synchronizer stages, FILT_LEN history stages, the filter output flop and the event register. A pulse is only judged at that point. The bench drives the flags on falling clock edges. A behavioural model, fed with the same samples, predicts the strobes for every edge, and the two are compared at each falling edge. Each scenario then counts the strobes within a tail window longer than that latency and checks the edge on which the first strobe arrived. Width and gap boundaries are probed one cycle either side of each limit.

// File: rtl/ppq_pkg.sv
package ppq_pkg;

    typedef enum logic [1:0] {
        ST_ARM    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_PULSE  = 2'd2,
        ST_REJECT = 2'd3
    } ppq_state_e;

    function automatic int us_to_cycles(input int clk_hz, input int usec);
        return (clk_hz / 1_000_000) * usec;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ppq_deglitch.sv
module ppq_deglitch #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);

    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '0;
            hist_q  <= '0;
            clean_o <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q) begin
                clean_o <= 1'b1;
            end else if (~|hist_q) begin
                clean_o <= 1'b0;
            end
        end
    end

    // R2
    clean_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_o != $past(clean_o)) |=> $stable(clean_o));

endmodule

// File: rtl/ppq_sat_cnt.sv
module ppq_sat_cnt #(
    parameter int W   = 13,
    parameter int MAX = 4500
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load1_i,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] LIMIT = W'(MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (load1_i) begin
            count_o <= W'(1);
        end else if (clr_i) begin
            count_o <= '0;
        end else if (inc_i && (count_o < LIMIT)) begin
            count_o <= count_o + W'(1);
        end
    end

    // R4
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load1_i && !clr_i && count_o == LIMIT) |=> (count_o == LIMIT));

endmodule

// File: rtl/prog_pulse_qualifier.sv
module prog_pulse_qualifier
    import ppq_pkg::*;
#(
    parameter int CLK_HZ        = 50_000_000,
    parameter int MIN_ACTIVE_US = 20,
    parameter int MIN_GAP_US    = 20,
    parameter int BLOW_MIN_US   = 90,
    parameter int FILT_LEN      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mid_cmp_i,
    input  logic high_cmp_i,
    output logic evt_mid_o,
    output logic evt_high_o,
    output logic evt_blow_o
);

    localparam int ACT_CYC  = us_to_cycles(CLK_HZ, MIN_ACTIVE_US);
    localparam int GAP_CYC  = us_to_cycles(CLK_HZ, MIN_GAP_US);
    localparam int BLOW_CYC = us_to_cycles(CLK_HZ, BLOW_MIN_US);
    localparam int CNT_MAX  = max3(ACT_CYC, GAP_CYC, BLOW_CYC);
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int NFLAG    = 2;

    localparam logic [CNT_W-1:0] ACT_LIM   = CNT_W'(ACT_CYC);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] HI_LAST   = CNT_W'(ACT_CYC - 1);
    localparam logic [CNT_W-1:0] BLOW_LAST = CNT_W'(BLOW_CYC - 1);

    // flag conditioning
    logic [NFLAG-1:0] raw_w;
    logic [NFLAG-1:0] flt_w;
    logic             active;
    logic             hflag;

    assign raw_w = {high_cmp_i, mid_cmp_i};

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        ppq_deglitch #(.FILT_LEN(FILT_LEN)) u_dg (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_w[gi]),
            .clean_o (flt_w[gi])
        );
    end

    assign active = |flt_w;
    assign hflag  = flt_w[1];

    // timers
    logic             a_load1, a_inc;
    logic             h_load1, h_clr, h_inc;
    logic             g_load1, g_inc;
    logic [CNT_W-1:0] acnt, hcnt, gcnt;

    ppq_sat_cnt #(.W(CNT_W), .MAX(CNT_MAX)) u_act_cnt (
        .clk(clk), .rst_n(rst_n), .load1_i(a_load1), .clr_i(1'b0),
        .inc_i(a_inc), .count_o(acnt)
    );

    ppq_sat_cnt #(.W(CNT_W), .MAX(CNT_MAX)) u_high_cnt (
        .clk(clk), .rst_n(rst_n), .load1_i(h_load1), .clr_i(h_clr),
        .inc_i(h_inc), .count_o(hcnt)
    );

    ppq_sat_cnt #(.W(CNT_W), .MAX(CNT_MAX)) u_gap_cnt (
        .clk(clk), .rst_n(rst_n), .load1_i(g_load1), .clr_i(1'b0),
        .inc_i(g_inc), .count_o(gcnt)
    );

    // controller
    ppq_state_e state_q, state_d;
    logic       start_w;
    logic       fall_w;
    logic       hok_q, bok_q;

    always_comb begin
        state_d = state_q;
        a_load1 = 1'b0;
        a_inc   = 1'b0;
        h_load1 = 1'b0;
        h_clr   = 1'b0;
        h_inc   = 1'b0;
        g_load1 = 1'b0;
        g_inc   = 1'b0;
        start_w = 1'b0;
        fall_w  = 1'b0;
        unique case (state_q)
            ST_ARM: begin
                if (active) begin
                    state_d = ST_REJECT;
                end else if (gcnt >= GAP_LAST) begin
                    state_d = ST_IDLE;
                end else begin
                    g_inc = 1'b1;
                end
            end
            ST_IDLE: begin
                if (active) begin
                    state_d = ST_PULSE;
                    start_w = 1'b1;
                    a_load1 = 1'b1;
                    h_load1 = hflag;
                    h_clr   = !hflag;
                end
            end
            ST_PULSE: begin
                if (active) begin
                    a_inc = 1'b1;
                    h_inc = hflag;
                    h_clr = !hflag;
                end else begin
                    state_d = ST_ARM;
                    fall_w  = 1'b1;
                    g_load1 = 1'b1;
                end
            end
            ST_REJECT: begin
                if (!active) begin
                    state_d = ST_ARM;
                    g_load1 = 1'b1;
                end
            end
            default: state_d = ST_ARM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_mid_o  <= 1'b0;
            evt_high_o <= 1'b0;
            evt_blow_o <= 1'b0;
            hok_q      <= 1'b0;
            bok_q      <= 1'b0;
        end else begin
            evt_mid_o  <= fall_w && (acnt >= ACT_LIM) && !hok_q;
            evt_high_o <= fall_w && (acnt >= ACT_LIM) && hok_q;
            evt_blow_o <= fall_w && (acnt >= ACT_LIM) && bok_q;
            if (start_w) begin
                hok_q <= 1'b0;
                bok_q <= 1'b0;
            end else if (state_q == ST_PULSE && active && hflag) begin
                if (hcnt >= HI_LAST)   hok_q <= 1'b1;
                if (hcnt >= BLOW_LAST) bok_q <= 1'b1;
            end
        end
    end

    // R8
    evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_mid_o && evt_high_o));

    // R7
    blow_with_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_blow_o |-> evt_high_o);

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mid_o || evt_high_o) |=> !(evt_mid_o || evt_high_o));

    // R3
    evt_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mid_o || evt_high_o) |-> (state_q == ST_ARM));

    // R4
    min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mid_o || evt_high_o) |-> ($past(acnt) >= ACT_LIM));

    // R5
    gap_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_PULSE) |-> ($past(gcnt) >= GAP_LAST));

endmodule

// File: tb/prog_pulse_qualifier_bench.sv
module prog_pulse_qualifier_bench;

    localparam int CLK_HZ = 50_000_000;
    localparam int FLT    = 4;
    localparam int MINW   = (CLK_HZ / 1_000_000) * 20;
    localparam int GAPW   = (CLK_HZ / 1_000_000) * 20;
    localparam int BLOWW  = (CLK_HZ / 1_000_000) * 90;
    localparam int TAIL   = 16;
    localparam int LAT    = FLT + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mid_cmp = 1'b0;
    logic high_cmp = 1'b0;
    logic evt_mid, evt_high, evt_blow;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    prog_pulse_qualifier #(
        .CLK_HZ(CLK_HZ), .MIN_ACTIVE_US(20), .MIN_GAP_US(20),
        .BLOW_MIN_US(90), .FILT_LEN(FLT)
    ) u_prog_pulse_qualifier (
        .clk(clk), .rst_n(rst_n), .mid_cmp_i(mid_cmp), .high_cmp_i(high_cmp),
        .evt_mid_o(evt_mid), .evt_high_o(evt_high), .evt_blow_o(evt_blow)
    );

    // behavioural reference
    bit qm[$];
    bit qh[$];
    bit fm = 0, fh = 0;
    int mst = 0, mg = 0, ma = 0, mh = 0;
    bit mhok = 0, mbok = 0;
    bit em = 0, eh = 0, eb = 0;

    function automatic bit all_same(input bit q[$], input bit v);
        for (int i = 3; i <= FLT + 2; i++) if (q[i] != v) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            qm = {}; qh = {};
            for (int i = 0; i < FLT + 3; i++) begin qm.push_back(1'b0); qh.push_back(1'b0); end
            fm = 0; fh = 0; mst = 0; mg = 0; ma = 0; mh = 0;
            mhok = 0; mbok = 0; em = 0; eh = 0; eb = 0;
        end else begin
            bit act;
            act = fm | fh;
            em = 0; eh = 0; eb = 0;
            if (mst == 0) begin
                if (act) mst = 3;
                else if (mg + 1 >= GAPW) mst = 1;
                else mg = mg + 1;
            end else if (mst == 1) begin
                if (act) begin mst = 2; ma = 1; mh = fh ? 1 : 0; mhok = 0; mbok = 0; end
            end else if (mst == 2) begin
                if (act) begin
                    ma = ma + 1;
                    if (fh) begin
                        mh = mh + 1;
                        if (mh >= MINW) mhok = 1;
                        if (mh >= BLOWW) mbok = 1;
                    end else mh = 0;
                end else begin
                    if (ma >= MINW) begin em = !mhok; eh = mhok; eb = mbok; end
                    mst = 0; mg = 1;
                end
            end else begin
                if (!act) begin mst = 0; mg = 1; end
            end
            qm.push_front(mid_cmp); void'(qm.pop_back());
            qh.push_front(high_cmp); void'(qh.pop_back());
            if (all_same(qm, 1'b1)) fm = 1; else if (all_same(qm, 1'b0)) fm = 0;
            if (all_same(qh, 1'b1)) fh = 1; else if (all_same(qh, 1'b0)) fh = 0;
        end
    end

    // per-cycle comparison (R3 timing, R8 strobe shape)
    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if ({evt_mid, evt_high, evt_blow} !== {em, eh, eb}) begin
                n_fail++;
                $display("FAIL R3 cycle compare at %0t: actual mid/high/blow=%b%b%b expected=%b%b%b",
                         $time, evt_mid, evt_high, evt_blow, em, eh, eb);
            end
        end
    end

    task automatic seg(input bit m, input bit h, input int n);
        mid_cmp = m; high_cmp = h;
        repeat (n) @(negedge clk);
    endtask

    task automatic tail_check(input int xm, input int xh, input int xb, input string req);
        int cm = 0, ch = 0, cb = 0, first = -1;
        mid_cmp = 1'b0; high_cmp = 1'b0;
        for (int k = 1; k <= TAIL; k++) begin
            @(negedge clk);
            if (evt_mid) cm++;
            if (evt_high) ch++;
            if (evt_blow) cb++;
            if ((evt_mid || evt_high) && first < 0) first = k;
        end
        n_chk++;
        if (cm != xm || ch != xh || cb != xb) begin
            n_fail++;
            $display("FAIL %s event counts: actual mid=%0d high=%0d blow=%0d expected mid=%0d high=%0d blow=%0d",
                     req, cm, ch, cb, xm, xh, xb);
        end
        if (xm + xh > 0) begin
            n_chk++;
            if (first != LAT) begin
                n_fail++;
                $display("FAIL R3 latency: actual edge %0d expected edge %0d", first, LAT);
            end
        end
    endtask

    initial begin
        repeat (5) begin
            @(negedge clk);
            n_chk++;
            if ({evt_mid, evt_high, evt_blow} !== 3'b000) begin
                n_fail++;
                $display("FAIL R1 in reset: actual %b%b%b expected 000", evt_mid, evt_high, evt_blow);
            end
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if ({evt_mid, evt_high, evt_blow} !== 3'b000) begin
            n_fail++;
            $display("FAIL R1 after release: actual %b%b%b expected 000", evt_mid, evt_high, evt_blow);
        end
        // R1 / R5: pulse before the post-reset gap is complete
        seg(0, 0, 500); seg(1, 0, 1500); tail_check(0, 0, 0, "R1");
        // R4: normal mid pulse
        seg(0, 0, 1200); seg(1, 0, 1500); tail_check(1, 0, 0, "R4");
        // R4: one cycle short
        seg(0, 0, 1200); seg(1, 0, MINW - 1); tail_check(0, 0, 0, "R4");
        // R4: exactly minimum
        seg(0, 0, 1200); seg(1, 0, MINW); tail_check(1, 0, 0, "R4");
        // R6: high run exactly minimum
        seg(0, 0, 1200); seg(1, 0, 200); seg(1, 1, MINW); seg(1, 0, 200); tail_check(0, 1, 0, "R6");
        // R6: high run one short -> mid
        seg(0, 0, 1200); seg(1, 0, 200); seg(1, 1, MINW - 1); seg(1, 0, 200); tail_check(1, 0, 0, "R6");
        // R7: blow exactly at limit
        seg(0, 0, 1200); seg(1, 0, 100); seg(1, 1, BLOWW); seg(1, 0, 100); tail_check(0, 1, 1, "R7");
        // R7: one short of blow
        seg(0, 0, 1200); seg(1, 0, 100); seg(1, 1, BLOWW - 1); seg(1, 0, 100); tail_check(0, 1, 0, "R7");
        // R5: gap one short, then exactly the minimum counted from the rejected pulse
        seg(0, 0, GAPW - TAIL - 1); seg(1, 0, 1500); tail_check(0, 0, 0, "R5");
        seg(0, 0, GAPW - TAIL); seg(1, 0, 1500); tail_check(1, 0, 0, "R5");
        // R6: two high runs, each below minimum, do not combine
        seg(0, 0, 1200); seg(1, 0, 100); seg(1, 1, 600); seg(1, 0, 100);
        seg(1, 1, 600); seg(1, 0, 100); tail_check(1, 0, 0, "R6");
        // R2: short spike inside the gap is ignored
        seg(0, 0, 600); seg(1, 0, FLT - 1); seg(0, 0, 600); seg(1, 0, 1500); tail_check(1, 0, 0, "R2");
        // R2: short dip inside a pulse is ignored
        seg(0, 0, 1200); seg(1, 0, 700); seg(0, 0, FLT - 1); seg(1, 0, 700); tail_check(1, 0, 0, "R2");
        // R8: high spike on the high flag alone is filtered too
        seg(0, 0, 1200); seg(1, 0, 600); seg(1, 1, FLT - 1); seg(1, 0, 600); tail_check(1, 0, 0, "R8");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule